// File: doc/BRIEF.md
# Coherent Two-Byte Error Counter

This block counts error pulses from a test-pattern checker in a 16-bit register and lets software read the count over an 8-bit register bus as two bytes. Every error pulse adds one to the count and sets a sticky error-detected flag. Software reads that flag through its own clear-on-read strobe.

Software first reads the low byte. That read stores a snapshot of the full count. The next high-byte read returns the high half of that snapshot, so the two bytes always come from the same instant. The high-byte read also ends the access and clears the live count, and counting goes on without a gap. Register-address decoding is done outside the block. The block sees only one read strobe for each byte and one for the status flag.

Top module: `err_cnt_top`

## Requirements
- R1: Each cycle with `err_inc_i` high raises the live count by exactly one, while the count is below 0xFFFF and no clear takes place in that cycle.
- R2: A cycle with `err_inc_i` high sets `err_flag_o` from the next cycle. The flag then stays set until it is cleared by a status read.
- R3: While `rd_lo_i` is high, `rdata_o` shows bits 7:0 of the live count. At that edge the full 16-bit count is stored as a snapshot and the block becomes armed.
- R4: A high-byte read (`rd_hi_i` high, `rd_lo_i` low) while armed shows bits 15:8 of the snapshot, even if the live count has changed since the low-byte read.
- R5: An armed high-byte read clears the armed state and restarts the live count. The new count is 0, or 1 if `err_inc_i` is high in the same cycle. Counting continues from there.
- R6: The count saturates at 0xFFFF. Further increments leave it at 0xFFFF.
- R7: A high-byte read while not armed shows bits 15:8 of the live count and leaves the count unchanged.
- R8: A cycle with `stat_rd_i` high clears `err_flag_o` from the next cycle, unless `err_inc_i` is also high in that cycle, in which case the flag stays set.
- R9: With no read strobe, `rdata_o` is 0. With `rd_lo_i` and `rd_hi_i` high together, the low-byte read wins: the count is not cleared and the block becomes armed.
- R10: After reset the count is 0, the flag is clear and the block is not armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| err_inc_i | input | 1 | Error pulse, one count per cycle |
| rd_lo_i | input | 1 | Low-byte read strobe |
| rd_hi_i | input | 1 | High-byte read strobe |
| stat_rd_i | input | 1 | Status read strobe, clears the flag |
| rdata_o | output | 8 | Read data for the byte being read |
| err_flag_o | output | 1 | Sticky error-detected flag |

## Verification
The bench aims at the cycle in which an error pulse coincides with the clearing high-byte read. A design that drops that pulse would restart the count at 0 instead of 1. It also drives increments between the two byte reads. A design without a true snapshot would then return a high byte that does not belong with the low byte. Unarmed high-byte reads and combined low/high strobes catch a design that clears the count when it should not. Running the count past 0xFFFF catches one that wraps to zero. A status read in the same cycle as an error pulse catches a flag that loses the new error.

// File: rtl/err_cnt_pkg.sv
package err_cnt_pkg;
  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_LO,
    SEL_HI_SNAP,
    SEL_HI_LIVE
  } rd_sel_e;
endpackage

// File: rtl/err_cnt_core.sv
module err_cnt_core #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inc_i,
  input  logic         clr_i,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] MAX = {W{1'b1}};
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (clr_i)            cnt_q <= inc_i ? ONE : '0;  // keep coincident pulse
    else if (inc_i && cnt_q != MAX) cnt_q <= cnt_q + ONE;
  end

  assign cnt_o = cnt_q;

  p_inc_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !clr_i && cnt_q != MAX) |=> cnt_q == $past(cnt_q) + ONE);
  p_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!inc_i && !clr_i) |=> $stable(cnt_q));
  p_restart_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> cnt_q == ($past(inc_i) ? ONE : '0));
  p_no_overflow_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == MAX && !clr_i) |=> cnt_q == MAX);
endmodule

// File: rtl/err_cnt_snap.sv
module err_cnt_snap #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         rd_lo_i,
  input  logic         rd_hi_i,
  input  logic [W-1:0] cnt_i,
  output logic [W-1:0] snap_o,
  output logic         armed_o,
  output logic         clr_o
);
  logic [W-1:0] snap_q;
  logic         armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      snap_q  <= '0;
      armed_q <= 1'b0;
    end else if (rd_lo_i) begin
      snap_q  <= cnt_i;
      armed_q <= 1'b1;
    end else if (rd_hi_i) begin
      armed_q <= 1'b0;
    end
  end

  assign snap_o  = snap_q;
  assign armed_o = armed_q;
  assign clr_o   = armed_q && rd_hi_i && !rd_lo_i;

  p_snap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_lo_i |=> (armed_q && snap_q == $past(cnt_i)));
  p_disarm_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_o |=> !armed_q);
  p_unarmed_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !armed_q |-> !clr_o);
endmodule

// File: rtl/err_cnt_flag.sv
module err_cnt_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic rd_i,
  output logic flag_o
);
  logic flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    flag_q <= 1'b0;
    else if (set_i) flag_q <= 1'b1;  // set wins over clear-on-read
    else if (rd_i)  flag_q <= 1'b0;
  end

  assign flag_o = flag_q;

  p_set_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> flag_q);
  p_clr_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !set_i) |=> !flag_q);
  p_sticky_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q && !rd_i) |=> flag_q);
endmodule

// File: rtl/err_cnt_top.sv
module err_cnt_top #(
  parameter int unsigned BUS_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             err_inc_i,
  input  logic             rd_lo_i,
  input  logic             rd_hi_i,
  input  logic             stat_rd_i,
  output logic [BUS_W-1:0] rdata_o,
  output logic             err_flag_o
);
  import err_cnt_pkg::*;

  localparam int unsigned CNT_W = 2 * BUS_W;

  logic [CNT_W-1:0] cnt_w;
  logic [CNT_W-1:0] snap_w;
  logic             armed_w;
  logic             clr_w;
  rd_sel_e          sel;

  err_cnt_core #(.W(CNT_W)) u_core (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .inc_i  (err_inc_i),
    .clr_i  (clr_w),
    .cnt_o  (cnt_w)
  );

  err_cnt_snap #(.W(CNT_W)) u_snap (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .rd_lo_i (rd_lo_i),
    .rd_hi_i (rd_hi_i),
    .cnt_i   (cnt_w),
    .snap_o  (snap_w),
    .armed_o (armed_w),
    .clr_o   (clr_w)
  );

  err_cnt_flag u_flag (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (err_inc_i),
    .rd_i   (stat_rd_i),
    .flag_o (err_flag_o)
  );

  always_comb begin
    if (rd_lo_i)      sel = SEL_LO;
    else if (rd_hi_i) sel = armed_w ? SEL_HI_SNAP : SEL_HI_LIVE;
    else              sel = SEL_NONE;
  end

  always_comb begin
    unique case (sel)
      SEL_LO:      rdata_o = cnt_w[BUS_W-1:0];
      SEL_HI_SNAP: rdata_o = snap_w[CNT_W-1 -: BUS_W];
      SEL_HI_LIVE: rdata_o = cnt_w[CNT_W-1 -: BUS_W];
      default:     rdata_o = '0;
    endcase
  end

  p_pair_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rd_lo_i) && rd_hi_i && !rd_lo_i) |-> rdata_o == $past(cnt_w[CNT_W-1 -: BUS_W]));
  p_both_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_lo_i && rd_hi_i) |=> armed_w);
endmodule

// File: tb/err_cnt_top_bench.sv
module err_cnt_top_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       err_inc_i = 1'b0;
  logic       rd_lo_i = 1'b0;
  logic       rd_hi_i = 1'b0;
  logic       stat_rd_i = 1'b0;
  logic [7:0] rdata_o;
  logic       err_flag_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  int m_cnt = 0, m_snap = 0;
  bit m_armed = 0, m_flag = 0;

  always #2.5 clk_i = ~clk_i;

  err_cnt_top u_err_cnt_top (
    .clk_i, .rst_ni, .err_inc_i, .rd_lo_i, .rd_hi_i, .stat_rd_i, .rdata_o, .err_flag_o
  );

  task automatic step(input bit inc, input bit lo, input bit hi, input bit st, input string tag);
    int exp_rd;
    bit clr;
    @(negedge clk_i);
    err_inc_i = inc; rd_lo_i = lo; rd_hi_i = hi; stat_rd_i = st;
    #1;
    if (lo)      exp_rd = m_cnt & 255;
    else if (hi) exp_rd = m_armed ? (m_snap >> 8) & 255 : (m_cnt >> 8) & 255;
    else         exp_rd = 0;
    checks++;
    if (rdata_o !== 8'(exp_rd)) begin
      errors++;
      $display("FAIL %s rdata: actual %0h expected %0h", tag, rdata_o, exp_rd);
    end
    checks++;
    if (err_flag_o !== m_flag) begin
      errors++;
      $display("FAIL %s flag: actual %0b expected %0b", tag, err_flag_o, m_flag);
    end
    @(posedge clk_i);
    clr = 0;
    if (lo) begin m_snap = m_cnt; m_armed = 1; end
    else if (hi) begin clr = m_armed; m_armed = 0; end
    if (clr) m_cnt = inc ? 1 : 0;
    else if (inc && m_cnt < 65535) m_cnt++;
    m_flag = inc || (m_flag && !st);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    step(0, 0, 0, 0, "R10");
    step(0, 0, 1, 0, "R10");
    step(0, 1, 0, 0, "R10");
    step(0, 0, 1, 0, "R10");
    for (int i = 0; i < 5; i++) step(1, 0, 0, 0, "R1");
    step(0, 0, 0, 0, "R2");
    step(0, 1, 0, 0, "R3");
    for (int i = 0; i < 300; i++) step(1, 0, 0, 0, "R1");
    step(0, 0, 1, 0, "R4");
    step(0, 1, 0, 0, "R5");
    step(0, 0, 1, 0, "R5");
    for (int i = 0; i < 3; i++) step(1, 0, 0, 0, "R5");
    step(0, 1, 0, 0, "R5");
    step(1, 0, 1, 0, "R5");
    step(0, 1, 0, 0, "R5");
    step(0, 0, 1, 0, "R5");
    for (int i = 0; i < 600; i++) step(1, 0, 0, 0, "R1");
    step(0, 0, 1, 0, "R7");
    step(0, 0, 1, 0, "R7");
    step(0, 1, 0, 0, "R7");
    step(0, 0, 0, 1, "R8");
    step(0, 0, 0, 0, "R8");
    step(1, 0, 0, 1, "R8");
    step(0, 0, 0, 1, "R8");
    step(0, 0, 0, 0, "R8");
    step(1, 1, 1, 0, "R9");
    step(0, 1, 0, 0, "R9");
    step(0, 0, 1, 0, "R9");
    step(0, 0, 0, 0, "R9");
    step(0, 0, 1, 0, "R9");
    for (int i = 0; i < 65540; i++) step(1, 0, 0, 0, "R6");
    step(0, 0, 1, 0, "R6");
    step(0, 1, 0, 0, "R6");
    step(1, 0, 0, 0, "R6");
    step(0, 0, 1, 0, "R6");
    step(0, 1, 0, 0, "R6");
    step(0, 0, 0, 0, "R9");
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule